// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer with a small 32-bit register port. The bus clock feeds a prescaler with four divide ratios. Each prescaler period decrements a down-counter. That counter starts from a coarse 12-bit reload field scaled up by a power of two. If software does not restart the counter before it reaches zero, the block raises a sticky status flag. It can then drive a level interrupt, a reset pulse of programmable length, or both. Every writable register checks a key carried inside the written word. This means a stray store from runaway code cannot disable the watchdog, reprogram it or feed it.

Software programs the control word (reload and prescaler) and then the mode word (enable, output selects, pulse length). After that it writes the restart word at regular intervals. The internal controller has three states:
- `ST_IDLE`: the block is disabled. The counter is held at its start value and the prescaler is cleared.
- `ST_COUNT`: the block is counting down.
- `ST_EXPIRED`: the counter has reached zero and is frozen there.

Its transitions are:
- enable: `ST_IDLE` to `ST_COUNT`.
- expire: `ST_COUNT` to `ST_EXPIRED`.
- restart: `ST_COUNT` or `ST_EXPIRED` to `ST_COUNT`.
- disable: any state to `ST_IDLE`.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the mode word reads 0 (disabled, both outputs off, pulse select 0). The control word reads 0x3FFC (reload field 0xFFF, prescaler select 0). The status word reads 0, and both outputs are low.
- R2: A write to word 0x0 (mode) is taken only when bits [23:12] equal 0xABC. The fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, and bits [5:4] pulse select. The key bits read back as zero, and a write with the wrong key leaves the word unchanged.
- R3: A write to word 0x4 (control) is taken only when bits [31:14] equal the pattern of 0x00920000. The fields are the reload value in bits [13:2] and the prescaler select in bits [1:0]. A write with the wrong key leaves the word unchanged.
- R4: Prescaler select 0, 1, 2 and 3 make one counter step every 8, 64, 512 and 4096 bus clocks respectively.
- R5: The start value is the reload field shifted left by RELOAD_SHIFT (12 by default, so the field times 4096). The status flag rises exactly start value times divide ratio cycles after the clock edge that enables or restarts the block.
- R6: Status bit 0 at word 0xC is set on expiry and stays set until a restart. The interrupt output is high while the status flag, interrupt enable and enable are all set.
- R7: On expiry with the reset output enabled, the reset output pulses once for 2, 4, 8 or 16 cycles for pulse select 0, 1, 2 or 3.
- R8: Only the exact word 0x00001999 written to word 0x8 restarts the block. A restart reloads the counter, clears the prescaler phase and clears the status flag. Any other value has no effect.
- R9: Clearing enable drops both outputs in the same cycle and stops counting. A later enable starts a full period from the start value.
- R10: A reload field of 0 expires after a single prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| wdata | input | 32 | Write data including the key |
| rdata | output | 32 | Read data for the word at addr, combinational |
| irq_o | output | 1 | Level timeout interrupt |
| wdt_rst_o | output | 1 | Timeout reset pulse |

## Verification
The bench builds the block with RELOAD_SHIFT set to 2. This makes the start value four times the reload field rather than 4096 times. With that setting, expiry under every prescaler ratio, including the divide-by-4096 case, takes at most a few tens of thousands of cycles. It also lets the zero-reload case and the frozen expired state be reached many times in one run. The other parameters keep their defaults, so the key positions, field positions and pulse lengths are the ones used in the product configuration.

// File: rtl/wdt_keyed_pkg.sv
`timescale 1ns/1ps
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_EXPIRED  = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } wdt_mode_t;

    localparam logic [1:0]  WORD_MODE    = 2'd0;
    localparam logic [1:0]  WORD_CTRL    = 2'd1;
    localparam logic [1:0]  WORD_KICK    = 2'd2;
    localparam logic [1:0]  WORD_STAT    = 2'd3;

    localparam logic [11:0] MODE_KEY     = 12'hABC;
    localparam logic [17:0] CTRL_KEY     = 18'h00248;
    localparam logic [31:0] KICK_WORD    = 32'h0000_1999;

    localparam int          PULSE_W      = 5;

    function automatic logic [PULSE_W-1:0] pulse_len(input logic [1:0] sel);
        return PULSE_W'(2) << sel;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_keyed_pkg::*;
#(
    parameter int RELOAD_W = 12,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    input  logic                stat,
    output wdt_mode_t           mode_q,
    output logic [RELOAD_W-1:0] reload_q,
    output logic [1:0]          psel_q,
    output logic                kick_o,
    output logic [31:0]         rdata
);

    logic [1:0] word;
    logic       mode_ok;
    logic       ctrl_ok;

    assign word    = addr[3:2];
    assign mode_ok = wr_en && (word == WORD_MODE) && (wdata[23:12] == MODE_KEY);
    assign ctrl_ok = wr_en && (word == WORD_CTRL) && (wdata[31:14] == CTRL_KEY);
    assign kick_o  = wr_en && (word == WORD_KICK) && (wdata == KICK_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reload_q <= '1;
            psel_q   <= 2'd0;
        end else begin
            if (mode_ok) begin
                mode_q.en     <= wdata[0];
                mode_q.rst_en <= wdata[1];
                mode_q.irq_en <= wdata[2];
                mode_q.plen   <= wdata[5:4];
            end
            if (ctrl_ok) begin
                reload_q <= wdata[RELOAD_W+1:2];
                psel_q   <= wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (word)
            WORD_MODE: rdata[5:0] = {mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
            WORD_CTRL: begin
                rdata[RELOAD_W+1:2] = reload_q;
                rdata[1:0]          = psel_q;
            end
            WORD_KICK: rdata = '0;
            WORD_STAT: rdata[0] = stat;
        endcase
    end

    AST_MODE_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_MODE && wdata[23:12] != MODE_KEY) |=> $stable(mode_q)); // R2
    AST_CTRL_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_CTRL && wdata[31:14] != CTRL_KEY) |=> ($stable(reload_q) && $stable(psel_q))); // R3

endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        unique case (sel)
            2'd0: last = PRE_W'(7);
            2'd1: last = PRE_W'(63);
            2'd2: last = PRE_W'(511);
            2'd3: last = PRE_W'(4095);
        endcase
    end

    assign tick = run && (phase_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clr || tick)
            phase_q <= '0;
        else if (run)
            phase_q <= phase_q + 1'b1;
    end

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == '0)); // R4
    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(phase_q)); // R4

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_keyed_pkg::*;
#(
    parameter int RELOAD_W     = 12,
    parameter int RELOAD_SHIFT = 12,
    localparam int CNT_W       = RELOAD_W + RELOAD_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wdt_mode_t           mode,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                kick,
    input  logic                tick,
    output logic                run,
    output logic                pre_clr,
    output logic                stat,
    output logic                irq_o,
    output logic                wdt_rst_o
);

    wdt_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   start_val;
    logic [PULSE_W-1:0] pulse_q;
    logic               expire_now;
    logic               pulse_on;

    assign start_val  = CNT_W'(reload) << RELOAD_SHIFT;
    assign run        = mode.en && (state_q != ST_EXPIRED);
    assign pre_clr    = !mode.en || kick;
    assign expire_now = run && tick && !kick && (cnt_q <= CNT_W'(1));
    assign pulse_on   = (pulse_q != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode.en)
                    state_d = expire_now ? ST_EXPIRED : ST_COUNT;
            end
            ST_COUNT: begin
                if (!mode.en)
                    state_d = ST_IDLE;
                else if (expire_now)
                    state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!mode.en)
                    state_d = ST_IDLE;
                else if (kick)
                    state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stat    <= 1'b0;
            pulse_q <= '0;
        end else begin
            if (!mode.en || kick)
                cnt_q <= start_val;
            else if (expire_now)
                cnt_q <= '0;
            else if (run && tick)
                cnt_q <= cnt_q - 1'b1;

            if (kick)
                stat <= 1'b0;
            else if (expire_now)
                stat <= 1'b1;

            if (!mode.en)
                pulse_q <= '0;
            else if (expire_now && mode.rst_en)
                pulse_q <= pulse_len(mode.plen);
            else if (pulse_on)
                pulse_q <= pulse_q - 1'b1;
        end
    end

    assign irq_o     = stat && mode.irq_en && mode.en;
    assign wdt_rst_o = pulse_on && mode.en;

    AST_EXPIRED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED) |-> (stat && cnt_q == '0)); // R6
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && mode.en && !kick && !tick) |=> (cnt_q == $past(cnt_q))); // R5
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && mode.en && !kick && tick && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.en && kick) |=> (cnt_q == $past(start_val) && !stat)); // R8
    AST_PULSE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> (state_q == ST_EXPIRED)); // R7

endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int RELOAD_W     = 12,
    parameter int RELOAD_SHIFT = 12,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    localparam int PRE_W = 12;

    wdt_mode_t           mode;
    logic [RELOAD_W-1:0] reload;
    logic [1:0]          psel;
    logic                kick;
    logic                tick;
    logic                run;
    logic                pre_clr;
    logic                stat;

    wdt_regs #(.RELOAD_W(RELOAD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .stat     (stat),
        .mode_q   (mode),
        .reload_q (reload),
        .psel_q   (psel),
        .kick_o   (kick),
        .rdata    (rdata)
    );

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .run   (run),
        .sel   (psel),
        .tick  (tick)
    );

    wdt_core #(.RELOAD_W(RELOAD_W), .RELOAD_SHIFT(RELOAD_SHIFT)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .reload    (reload),
        .kick      (kick),
        .tick      (tick),
        .run       (run),
        .pre_clr   (pre_clr),
        .stat      (stat),
        .irq_o     (irq_o),
        .wdt_rst_o (wdt_rst_o)
    );

endmodule

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;

    localparam int SH = 2;
    localparam logic [31:0] MK = 32'h00AB_C000;
    localparam logic [31:0] CK = 32'h0092_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_out;

    always #2 clk = ~clk;

    wdt_keyed #(.RELOAD_W(12), .RELOAD_SHIFT(SH), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq), .wdt_rst_o(rst_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_en, m_rsten, m_irqen, m_plen, m_reload, m_psel;
    int m_pre, m_cnt, m_stat, m_pulse, m_exp;
    bit model_ok = 0;

    always @(posedge clk) begin
        int div, start;
        bit restart, tk, ex;
        if (!rst_n) begin
            m_en = 0; m_rsten = 0; m_irqen = 0; m_plen = 0; m_reload = 4095; m_psel = 0;
            m_pre = 0; m_cnt = 0; m_stat = 0; m_pulse = 0; m_exp = 0;
            model_ok = 1;
        end else begin
            div     = 8 << (3 * m_psel);
            start   = m_reload << SH;
            restart = wr_en && addr[3:2] == 2'd2 && wdata == 32'h1999;
            tk      = m_en != 0 && m_exp == 0 && m_pre >= div - 1;
            ex      = tk && m_cnt <= 1 && !restart;
            if (m_en == 0) begin
                m_pre = 0; m_cnt = start; m_exp = 0; m_pulse = 0;
            end else begin
                if (m_pulse > 0) m_pulse--;
                if (restart) begin
                    m_cnt = start; m_pre = 0; m_exp = 0;
                end else if (m_exp == 0) begin
                    if (tk) begin
                        m_pre = 0;
                        if (ex) begin
                            m_cnt = 0; m_exp = 1;
                            if (m_rsten != 0) m_pulse = 2 << m_plen;
                        end else m_cnt--;
                    end else m_pre++;
                end
            end
            if (restart) m_stat = 0;
            else if (ex) m_stat = 1;
            if (wr_en && addr[3:2] == 2'd0 && wdata[23:12] == 12'hABC) begin
                m_en = wdata[0]; m_rsten = wdata[1]; m_irqen = wdata[2]; m_plen = wdata[5:4];
            end
            if (wr_en && addr[3:2] == 2'd1 && wdata[31:14] == 18'h248) begin
                m_reload = wdata[13:2]; m_psel = wdata[1:0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [1:0] w);
        case (w)
            2'd0: return 32'((m_plen << 4) | (m_irqen << 2) | (m_rsten << 1) | m_en);
            2'd1: return 32'((m_reload << 2) | m_psel);
            2'd2: return 32'h0;
            default: return 32'(m_stat);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && model_ok && !finished) begin
            check("R6 interrupt level", 32'(irq), 32'(m_stat != 0 && m_irqen != 0 && m_en != 0));
            check("R7 reset pulse", 32'(rst_out), 32'(m_pulse > 0 && m_en != 0));
            case (addr[3:2])
                2'd0: check("R2 mode readback", rdata, exp_read(2'd0));
                2'd1: check("R3 control readback", rdata, exp_read(2'd1));
                2'd2: check("R8 restart word reads zero", rdata, exp_read(2'd2));
                default: check("R6 status readback", rdata, exp_read(2'd3));
            endcase
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            addr = addr + 4'h4;
        end
    endtask

    task automatic peek(input logic [3:0] a, input string tag, input logic [31:0] exp);
        @(posedge clk); #1; addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
    endtask

    // call right after the enabling or restarting write
    task automatic wait_expiry(input int n, input string tag);
        addr = 4'hC;
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        check({tag, " before"}, rdata, 32'h0);
        @(negedge clk);
        check({tag, " at"}, rdata, 32'h1);
    endtask

    task automatic pulse_len(input int exp, input string tag);
        int c;
        c = rst_out ? 1 : 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (rst_out) c++;
        end
        check(tag, 32'(c), 32'(exp));
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired (all requirements): actual hung expected done");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        peek(4'h0, "R1 mode after reset", 32'h0);
        peek(4'h4, "R1 control after reset", 32'h3FFC);
        peek(4'hC, "R1 status after reset", 32'h0);
        check("R1 outputs low", 32'({irq, rst_out}), 32'h0);

        wr(4'h0, 32'h00AB_B007);
        peek(4'h0, "R2 wrong key ignored", 32'h0);
        wr(4'h4, 32'h0093_0000 | (3 << 2));
        peek(4'h4, "R3 wrong key ignored", 32'h3FFC);
        wr(4'h4, 32'h0000_000C);
        peek(4'h4, "R3 keyless write ignored", 32'h3FFC);

        wr(4'h4, CK | (3 << 2) | 0);
        peek(4'h4, "R3 keyed control write", 32'h0000_000C);
        wr(4'h0, MK | (3 << 4) | 7);
        peek(4'h0, "R2 keyed mode write, key reads zero", 32'h37);

        wr(4'h8, 32'h1999);
        wait_expiry(8 * 12, "R5 expiry div8 reload3");
        check("R6 interrupt raised", 32'(irq), 32'h1);
        pulse_len(16, "R7 pulse length sel3");
        peek(4'hC, "R6 status sticky", 32'h1);

        wr(4'h8, 32'h0001_1999);
        peek(4'hC, "R8 wrong restart word ignored", 32'h1);
        wr(4'h8, 32'h1999);
        @(negedge clk);
        check("R8 restart clears status", rdata, 32'h0);
        check("R8 restart clears interrupt", 32'(irq), 32'h0);
        wait_expiry(8 * 12, "R8 expiry after restart");

        wr(4'h4, CK | (1 << 2) | 1);
        wr(4'h0, MK | (0 << 4) | 7);
        wr(4'h8, 32'h1999);
        wait_expiry(64 * 4, "R4 divide by 64");
        pulse_len(2, "R7 pulse length sel0");

        wr(4'h4, CK | (1 << 2) | 2);
        wr(4'h0, MK | (1 << 4) | 7);
        wr(4'h8, 32'h1999);
        wait_expiry(512 * 4, "R4 divide by 512");
        pulse_len(4, "R7 pulse length sel1");

        wr(4'h4, CK | (1 << 2) | 3);
        wr(4'h0, MK | (2 << 4) | 7);
        wr(4'h8, 32'h1999);
        wait_expiry(4096 * 4, "R4 divide by 4096");
        pulse_len(8, "R7 pulse length sel2");

        wr(4'h4, CK | 0);
        wr(4'h8, 32'h1999);
        wait_expiry(8, "R10 zero reload");

        wr(4'h4, CK | (3 << 2) | 0);
        wr(4'h0, MK | (3 << 4) | 7);
        wr(4'h8, 32'h1999);
        idle(40);
        wr(4'h0, MK | (3 << 4) | 6);
        idle(300);
        peek(4'hC, "R9 disabled block does not expire", 32'h0);
        wr(4'h0, MK | (3 << 4) | 7);
        wait_expiry(8 * 12, "R9 full period after re-enable");
        wr(4'h0, MK | (3 << 4) | 6);
        @(negedge clk);
        check("R9 outputs drop on disable", 32'({irq, rst_out}), 32'h0);
        peek(4'hC, "R9 status kept while disabled", 32'h1);

        wr(4'h0, MK | (3 << 4) | 7);
        wr(4'h8, 32'h1999);
        idle(50);
        wr(4'h8, 32'h1999);
        wait_expiry(8 * 12, "R8 restart mid count");
        idle(30);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule